// File: doc/BRIEF.md
# Serial Port Register Front End with Receive Queue

This block is the processor-facing side of a serial port. A 32-bit peripheral bus reaches its registers through an address, write and read strobes and write data. Read data is combinational from the current state. A read or write takes effect at the clock edge that samples the strobe. The register is picked by the byte address shifted right by two. Received characters arrive on a valid-qualified input word: eight data bits plus four error bits. They wait in a 16-entry queue until software reads the data register.

A write to the data register sends its low byte out on a one-cycle transmit strobe. The block keeps line-control, control, level-select, low-power divisor, baud divisor and DMA-control words as storage only. It also keeps a receive-status word, a flag word, and raw, mask and masked interrupt views with write-one-to-clear. A fixed eight-word identification window sits at the top of the 4 KB space. One level interrupt line is the OR of all masked bits.

Top module: `uart_regfile`

## Requirements
- R1: After reset the flag word reads 0x90, control reads 0x300, level select reads 0x12, every other register reads 0, and the interrupt line is low.
- R2: Word index (byte address >> 2) picks the register. Storage words read back exactly what was written: low-power divisor 8, integer divisor 9, fractional divisor 10, line control 11, control 12, level select 13, mask 14, DMA control 18. Nonzero DMA enable bits change nothing else.
- R3: An accepted receive word clears flag bit 4 (receive empty). It sets flag bit 6 (receive full) if line-control bit 4 (queue enable) is 0, or if the held count has reached 16.
- R4: The queue returns words in arrival order. A word that arrives while 16 are held is dropped and the count is unchanged.
- R5: A read of index 0 returns the oldest held word in bits 11:0, or 0 when empty. It pops that word and loads the receive-status word (index 1) with the popped word shifted right by 8. Any write to index 1 zeroes the receive-status word.
- R6: A read of index 0 clears receive full. It sets receive empty when the count after the pop is 0.
- R7: Raw interrupt bit 4 (receive) sets when an accepted word leaves the count at or above the trigger level of 1. It clears on a data read that leaves the count at exactly 0.
- R8: A write to index 0 gives `tx_strobe` high for exactly the next cycle, with `tx_byte` equal to the written bits 7:0. It also sets raw interrupt bit 5 (transmit).
- R9: Index 15 reads the raw bits and index 16 reads raw AND mask. Writing index 17 clears only the raw bits written as 1. `irq` is high exactly when some masked bit is set.
- R10: A line-control write that changes bit 4 empties the queue count (the next word pushed is the next word read) and leaves the flag bits as they were.
- R11: Writes to the flag word are ignored. Reads of unmapped indices, including the clear register, return 0.
- R12: Indices 0x3F8 to 0x3FF read, one byte per word in bits 7:0, the values 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (reads of index 0 pop) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| rx_valid | input | 1 | Receive word present |
| rx_word | input | 12 | Error bits 11:8 and character 7:0 |
| tx_strobe | output | 1 | One-cycle transmit pulse |
| tx_byte | output | 8 | Transmitted character |
| irq | output | 1 | Level interrupt |

## Verification
The hardest states to reach from the ports are a full queue that drops a seventeenth word, and a line-control toggle that zeroes the count while the flags keep their old values. The stimulus fills the queue to 16 with distinct words and offers one more. It then drains all sixteen and checks the order, which shows that the extra word never entered. For the toggle, three words are left in the queue when line control is flipped. Then one new word is pushed and read back: it comes out first, and the pop alone brings back receive empty.

// File: rtl/uart_regfile_pkg.sv
package uart_regfile_pkg;

    localparam int BUS_AW = 12;
    localparam int IDX_W  = BUS_AW - 2;

    localparam logic [IDX_W-1:0] IX_DATA  = 10'd0;
    localparam logic [IDX_W-1:0] IX_RSTAT = 10'd1;
    localparam logic [IDX_W-1:0] IX_FLAG  = 10'd6;
    localparam logic [IDX_W-1:0] IX_LPDIV = 10'd8;
    localparam logic [IDX_W-1:0] IX_IDIV  = 10'd9;
    localparam logic [IDX_W-1:0] IX_FDIV  = 10'd10;
    localparam logic [IDX_W-1:0] IX_LCTL  = 10'd11;
    localparam logic [IDX_W-1:0] IX_CTL   = 10'd12;
    localparam logic [IDX_W-1:0] IX_LVL   = 10'd13;
    localparam logic [IDX_W-1:0] IX_MASK  = 10'd14;
    localparam logic [IDX_W-1:0] IX_RAW   = 10'd15;
    localparam logic [IDX_W-1:0] IX_MST   = 10'd16;
    localparam logic [IDX_W-1:0] IX_ICLR  = 10'd17;
    localparam logic [IDX_W-1:0] IX_DMA   = 10'd18;

    // identification window occupies the last eight words
    localparam logic [IDX_W-4:0] ID_PAGE = 7'h7F;

    localparam int FEN_BIT  = 4;
    localparam int IRQ_LSB  = 4;

    localparam logic [31:0] CTL_RST = 32'h0000_0300;
    localparam logic [31:0] LVL_RST = 32'h0000_0012;

    typedef struct packed {
        logic [31:0] lp_div;
        logic [31:0] int_div;
        logic [31:0] frac_div;
        logic [31:0] line_ctl;
        logic [31:0] ctl;
        logic [31:0] lvl_sel;
        logic [31:0] int_mask;
        logic [31:0] dma_ctl;
    } cfg_t;

    typedef struct packed {
        logic             wr;
        logic             rd;
        logic [IDX_W-1:0] idx;
        logic [31:0]      wdata;
    } bus_req_t;

    // interrupt bits: index 0 = receive, index 1 = transmit
    typedef struct packed {
        logic tx;
        logic rx;
    } irq_vec_t;

    function automatic logic [7:0] id_byte(input logic [2:0] k);
        case (k)
            3'd0:    id_byte = 8'h11;
            3'd1:    id_byte = 8'h10;
            3'd2:    id_byte = 8'h14;
            3'd3:    id_byte = 8'h00;
            3'd4:    id_byte = 8'h0D;
            3'd5:    id_byte = 8'hF0;
            3'd6:    id_byte = 8'h05;
            default: id_byte = 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
    parameter int W     = 12,
    parameter int DEPTH = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_i,
    input  logic [W-1:0]     data_i,
    input  logic             pop_i,
    input  logic             flush_i,
    output logic [W-1:0]     head_o,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] cnt_pop_o,
    output logic [CNT_W-1:0] cnt_nxt_o,
    output logic             push_ok_o
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] count_q;
    logic             pop_eff;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) bump = '0;
        else                        bump = p + PTR_W'(1);
    endfunction

    always_comb begin
        pop_eff   = pop_i && (count_q != '0) && !flush_i;
        cnt_pop_o = count_q - CNT_W'(pop_eff);
        push_ok_o = push_i && !flush_i && (cnt_pop_o < CNT_W'(DEPTH));
        cnt_nxt_o = flush_i ? '0 : (cnt_pop_o + CNT_W'(push_ok_o));
        head_o    = (count_q == '0) ? '0 : mem[rd_ptr];
        count_o   = count_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr  <= '0;
            wr_ptr  <= '0;
            count_q <= '0;
        end else if (flush_i) begin
            rd_ptr  <= '0;
            wr_ptr  <= '0;
            count_q <= '0;
        end else begin
            if (pop_eff)   rd_ptr <= bump(rd_ptr);
            if (push_ok_o) wr_ptr <= bump(wr_ptr);
            count_q <= cnt_nxt_o;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok_o) mem[wr_ptr] <= data_i;
    end

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_regfile_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  irq_vec_t set_i,
    input  irq_vec_t clr_i,
    input  irq_vec_t mask_i,
    output irq_vec_t raw_o,
    output irq_vec_t masked_o,
    output logic     irq_o
);

    irq_vec_t raw_q;

    // clear first, then set: a same-cycle event wins over the clear
    always_ff @(posedge clk) begin
        if (rst) raw_q <= '0;
        else     raw_q <= (raw_q & ~clr_i) | set_i;
    end

    always_comb begin
        raw_o    = raw_q;
        masked_o = raw_q & mask_i;
        irq_o    = |masked_o;
    end

endmodule

// File: rtl/uart_id_rom.sv
module uart_id_rom
    import uart_regfile_pkg::*;
(
    input  logic [IDX_W-1:0] idx_i,
    output logic             hit_o,
    output logic [7:0]       byte_o
);

    always_comb begin
        hit_o  = (idx_i[IDX_W-1:3] == ID_PAGE);
        byte_o = hit_o ? id_byte(idx_i[2:0]) : 8'h00;
    end

endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
    import uart_regfile_pkg::*;
#(
    parameter int RX_W  = 12,
    parameter int DEPTH = 16,
    parameter int TRIG  = 1,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int ERR_W = RX_W - 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              rx_valid,
    input  logic [RX_W-1:0]   rx_word,
    output logic              tx_strobe,
    output logic [7:0]        tx_byte,
    output logic              irq
);

    bus_req_t         req;
    cfg_t             cfg_q;
    logic [ERR_W-1:0] rstat_q;
    logic             rxe_q, rxf_q, rxe_d, rxf_d;

    logic             pop_req, flush, data_wr;
    logic [RX_W-1:0]  head;
    logic [CNT_W-1:0] fifo_count, cnt_pop, cnt_nxt;
    logic             push_ok;

    irq_vec_t         irq_set, irq_clr, irq_mask, raw, masked;
    logic             id_hit;
    logic [7:0]       id_val;
    logic [7:0]       flag_word;

    always_comb begin
        req.wr    = bus_wr;
        req.rd    = bus_rd;
        req.idx   = bus_addr[BUS_AW-1:2];
        req.wdata = bus_wdata;
    end

    assign pop_req = req.rd && (req.idx == IX_DATA);
    assign data_wr = req.wr && (req.idx == IX_DATA);
    assign flush   = req.wr && (req.idx == IX_LCTL) &&
                     (req.wdata[FEN_BIT] != cfg_q.line_ctl[FEN_BIT]);

    uart_rx_fifo #(.W(RX_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push_i    (rx_valid),
        .data_i    (rx_word),
        .pop_i     (pop_req),
        .flush_i   (flush),
        .head_o    (head),
        .count_o   (fifo_count),
        .cnt_pop_o (cnt_pop),
        .cnt_nxt_o (cnt_nxt),
        .push_ok_o (push_ok)
    );

    // flag bits: pop effects first, then the push effects
    always_comb begin
        rxe_d = rxe_q;
        rxf_d = rxf_q;
        if (pop_req) begin
            rxf_d = 1'b0;
            if (cnt_pop == '0) rxe_d = 1'b1;
        end
        if (push_ok) begin
            rxe_d = 1'b0;
            if (!cfg_q.line_ctl[FEN_BIT] || (cnt_nxt == CNT_W'(DEPTH))) rxf_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rxe_q <= 1'b1;
            rxf_q <= 1'b0;
        end else begin
            rxe_q <= rxe_d;
            rxf_q <= rxf_d;
        end
    end

    assign flag_word = {1'b1, rxf_q, 1'b0, rxe_q, 4'b0000};

    // receive status
    always_ff @(posedge clk) begin
        if (rst)                                  rstat_q <= '0;
        else if (req.wr && req.idx == IX_RSTAT)   rstat_q <= '0;
        else if (pop_req)                         rstat_q <= head[RX_W-1:8];
    end

    // storage words
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q         <= '0;
            cfg_q.ctl     <= CTL_RST;
            cfg_q.lvl_sel <= LVL_RST;
        end else if (req.wr) begin
            case (req.idx)
                IX_LPDIV: cfg_q.lp_div   <= req.wdata;
                IX_IDIV:  cfg_q.int_div  <= req.wdata;
                IX_FDIV:  cfg_q.frac_div <= req.wdata;
                IX_LCTL:  cfg_q.line_ctl <= req.wdata;
                IX_CTL:   cfg_q.ctl      <= req.wdata;
                IX_LVL:   cfg_q.lvl_sel  <= req.wdata;
                IX_MASK:  cfg_q.int_mask <= req.wdata;
                IX_DMA:   cfg_q.dma_ctl  <= req.wdata;
                default: ;
            endcase
        end
    end

    // transmit side
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_strobe <= 1'b0;
            tx_byte   <= '0;
        end else begin
            tx_strobe <= data_wr;
            if (data_wr) tx_byte <= req.wdata[7:0];
        end
    end

    // interrupts
    always_comb begin
        irq_set.rx = push_ok && (cnt_nxt >= CNT_W'(TRIG));
        irq_set.tx = data_wr;
        irq_clr    = '0;
        if (pop_req && (cnt_pop == CNT_W'(TRIG - 1))) irq_clr.rx = 1'b1;
        if (req.wr && req.idx == IX_ICLR) begin
            irq_clr.rx = irq_clr.rx | req.wdata[IRQ_LSB];
            irq_clr.tx = req.wdata[IRQ_LSB+1];
        end
        irq_mask = irq_vec_t'(cfg_q.int_mask[IRQ_LSB+1:IRQ_LSB]);
    end

    uart_irq_ctrl u_irq (
        .clk      (clk),
        .rst      (rst),
        .set_i    (irq_set),
        .clr_i    (irq_clr),
        .mask_i   (irq_mask),
        .raw_o    (raw),
        .masked_o (masked),
        .irq_o    (irq)
    );

    uart_id_rom u_id (
        .idx_i  (req.idx),
        .hit_o  (id_hit),
        .byte_o (id_val)
    );

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (req.idx)
            IX_DATA:  bus_rdata = 32'(head);
            IX_RSTAT: bus_rdata = 32'(rstat_q);
            IX_FLAG:  bus_rdata = 32'(flag_word);
            IX_LPDIV: bus_rdata = cfg_q.lp_div;
            IX_IDIV:  bus_rdata = cfg_q.int_div;
            IX_FDIV:  bus_rdata = cfg_q.frac_div;
            IX_LCTL:  bus_rdata = cfg_q.line_ctl;
            IX_CTL:   bus_rdata = cfg_q.ctl;
            IX_LVL:   bus_rdata = cfg_q.lvl_sel;
            IX_MASK:  bus_rdata = cfg_q.int_mask;
            IX_RAW:   bus_rdata = 32'(raw) << IRQ_LSB;
            IX_MST:   bus_rdata = 32'(masked) << IRQ_LSB;
            IX_DMA:   bus_rdata = cfg_q.dma_ctl;
            default:  bus_rdata = id_hit ? 32'(id_val) : '0;
        endcase
    end

endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic [11:0]      bus_addr,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [31:0]      bus_wdata,
    input logic             rx_valid,
    input logic             tx_strobe,
    input logic [7:0]       tx_byte,
    input logic             irq,
    input logic [CNT_W-1:0] count,
    input logic             rxf,
    input logic             rxe,
    input logic [1:0]       raw,
    input logic [1:0]       mask
);

    logic [9:0] idx;
    assign idx = bus_addr[11:2];

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    p_tx_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && idx == 10'd0) |=> (tx_strobe && tx_byte == $past(bus_wdata[7:0])));

    p_pop_clears_full_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && idx == 10'd0 && !rx_valid) |=> !rxf);

    p_flag_write_ignored_r11: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && idx == 10'd6 && !rx_valid && !bus_rd) |=> ($stable(rxf) && $stable(rxe)));

    p_rx_raw_sets_r7: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !bus_wr && !bus_rd && count < CNT_W'(DEPTH)) |=> raw[0]);

    p_irq_masked_r9: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((raw & mask) != 2'b00));

endmodule

bind uart_regfile uart_regfile_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .rx_valid  (rx_valid),
    .tx_strobe (tx_strobe),
    .tx_byte   (tx_byte),
    .irq       (irq),
    .count     (fifo_count),
    .rxf       (rxf_q),
    .rxe       (rxe_q),
    .raw       (raw),
    .mask      (cfg_q.int_mask[5:4])
);

// File: tb/uart_regfile_tb.sv
module uart_regfile_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0;
    logic [11:0] rx_word = '0;
    logic        tx_strobe;
    logic [7:0]  tx_byte;
    logic        irq;

    always #4 clk = ~clk;

    uart_regfile u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rx_valid  (rx_valid),
        .rx_word   (rx_word),
        .tx_strobe (tx_strobe),
        .tx_byte   (tx_byte),
        .irq       (irq)
    );

    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;
    logic [31:0] rd_exp_q[$];
    string       rd_tag_q[$];
    logic [7:0]  tx_exp_q[$];

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // read monitor: compares bus data mid-cycle while the read strobe is up
    always @(negedge clk) begin
        if (!rst && bus_rd) begin
            if (rd_exp_q.size() == 0) check(1'b0, "read-scoreboard", bus_rdata, 32'hX);
            else begin
                automatic logic [31:0] e = rd_exp_q.pop_front();
                automatic string       t = rd_tag_q.pop_front();
                check(bus_rdata === e, t, bus_rdata, e);
            end
        end
    end

    // transmit monitor
    always @(negedge clk) begin
        if (!rst && tx_strobe) begin
            if (tx_exp_q.size() == 0) check(1'b0, "R8 unexpected strobe", 32'(tx_byte), 32'h0);
            else begin
                automatic logic [7:0] e = tx_exp_q.pop_front();
                check(tx_byte === e, "R8 tx byte", 32'(tx_byte), 32'(e));
            end
        end
    end

    task automatic t_wr(input logic [9:0] idx, input logic [31:0] d);
        bus_addr = {idx, 2'b00}; bus_wdata = d; bus_wr = 1'b1;
        if (idx == 10'd0) tx_exp_q.push_back(d[7:0]);
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic t_rd(input logic [9:0] idx, input logic [31:0] e, input string tag);
        bus_addr = {idx, 2'b00}; bus_rd = 1'b1;
        rd_exp_q.push_back(e); rd_tag_q.push_back(tag);
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic t_push(input logic [11:0] w);
        rx_word = w; rx_valid = 1'b1;
        @(posedge clk); #1;
        rx_valid = 1'b0;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 32'h0, 32'h1);
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        check(irq === 1'b0, "R1 irq", 32'(irq), 32'h0);
        t_rd(10'd6,  32'h90,  "R1 flags");
        t_rd(10'd12, 32'h300, "R1 control");
        t_rd(10'd13, 32'h12,  "R1 level");
        t_rd(10'd11, 32'h0,   "R1 line ctl");
        t_rd(10'd14, 32'h0,   "R1 mask");
        t_rd(10'd15, 32'h0,   "R1 raw");
        t_rd(10'd1,  32'h0,   "R1 rx status");

        // R2 storage words
        t_wr(10'd9,  32'h1A);
        t_wr(10'd10, 32'h05);
        t_wr(10'd8,  32'h3C);
        t_wr(10'd12, 32'h301);
        t_wr(10'd13, 32'h09);
        t_wr(10'd18, 32'h3);
        t_rd(10'd9,  32'h1A,  "R2 int div");
        t_rd(10'd10, 32'h05,  "R2 frac div");
        t_rd(10'd8,  32'h3C,  "R2 lp div");
        t_rd(10'd12, 32'h301, "R2 control");
        t_rd(10'd13, 32'h09,  "R2 level");
        t_rd(10'd18, 32'h3,   "R2 dma");

        // R11 ignored write and unmapped reads
        t_wr(10'd6, 32'hFFFF_FFFF);
        t_rd(10'd6,   32'h90, "R11 flag write ignored");
        t_rd(10'd2,   32'h0,  "R11 unmapped 2");
        t_rd(10'd17,  32'h0,  "R11 clear reg read");
        t_rd(10'h3F0, 32'h0,  "R11 unmapped 0x3F0");

        // R12 identification window
        t_rd(10'h3F8, 32'h11, "R12 id0");
        t_rd(10'h3F9, 32'h10, "R12 id1");
        t_rd(10'h3FA, 32'h14, "R12 id2");
        t_rd(10'h3FB, 32'h00, "R12 id3");
        t_rd(10'h3FC, 32'h0D, "R12 id4");
        t_rd(10'h3FD, 32'hF0, "R12 id5");
        t_rd(10'h3FE, 32'h05, "R12 id6");
        t_rd(10'h3FF, 32'hB1, "R12 id7");

        // queue disabled: one word is full
        t_push(12'h141);
        t_rd(10'd6,  32'hC0, "R3 full with queue off");
        t_rd(10'd15, 32'h10, "R7 rx raw set");
        check(irq === 1'b0, "R9 irq masked off", 32'(irq), 32'h0);
        t_wr(10'd14, 32'h10);
        check(irq === 1'b1, "R9 irq on mask", 32'(irq), 32'h1);
        t_rd(10'd16, 32'h10, "R9 masked view");
        t_rd(10'd0,  32'h141, "R5 data pop");
        t_rd(10'd6,  32'h90, "R6 flags after pop");
        t_rd(10'd15, 32'h0,  "R7 rx raw cleared");
        check(irq === 1'b0, "R7 irq drops", 32'(irq), 32'h0);
        t_rd(10'd1,  32'h1,  "R5 rx status");
        t_wr(10'd1,  32'h0);
        t_rd(10'd1,  32'h0,  "R5 status cleared");

        // queue enabled: fill to 16, drop the 17th
        t_wr(10'd11, 32'h10);
        t_rd(10'd11, 32'h10, "R2 line ctl");
        for (int i = 0; i < 17; i++) begin
            t_push(12'h020 + 12'(i));
            if (i == 14) t_rd(10'd6, 32'h80, "R3 fifteen held not full");
            if (i == 15) t_rd(10'd6, 32'hC0, "R3 full at sixteen");
        end
        t_rd(10'd6, 32'hC0, "R4 after dropped word");
        check(irq === 1'b1, "R7 irq with data", 32'(irq), 32'h1);
        for (int i = 0; i < 16; i++) begin
            t_rd(10'd0, 32'h020 + 32'(i), "R4 order");
            if (i == 0) t_rd(10'd6, 32'h80, "R6 pop clears full");
        end
        t_rd(10'd6, 32'h90, "R6 empty after drain");
        t_rd(10'd0, 32'h0,  "R5 empty read");
        check(irq === 1'b0, "R7 irq after drain", 32'(irq), 32'h0);

        // transmit
        t_wr(10'd0, 32'h1234_56A5);
        check(tx_strobe === 1'b1, "R8 strobe high", 32'(tx_strobe), 32'h1);
        @(posedge clk); #1;
        check(tx_strobe === 1'b0, "R8 strobe one cycle", 32'(tx_strobe), 32'h0);
        t_rd(10'd15, 32'h20, "R8 tx raw");
        check(irq === 1'b0, "R9 tx masked", 32'(irq), 32'h0);
        t_wr(10'd14, 32'h30);
        check(irq === 1'b1, "R9 tx unmasked", 32'(irq), 32'h1);
        t_rd(10'd16, 32'h20, "R9 masked tx");
        t_push(12'h0AB);
        t_rd(10'd15, 32'h30, "R9 both raw");
        t_wr(10'd17, 32'h20);
        t_rd(10'd15, 32'h10, "R9 clear only tx");
        t_wr(10'd17, 32'h10);
        t_rd(10'd15, 32'h0,  "R9 clear rx");
        check(irq === 1'b0, "R9 irq clear", 32'(irq), 32'h0);

        // queue flush by toggling the enable bit
        t_push(12'h0AC);
        t_push(12'h0AD);
        t_wr(10'd11, 32'h00);
        t_rd(10'd6, 32'h80, "R10 flags kept");
        t_push(12'h0EE);
        t_rd(10'd6, 32'hC0, "R10 full after push");
        t_rd(10'd0, 32'h0EE, "R10 new word first");
        t_rd(10'd6, 32'h90, "R10 empty after one pop");
        t_rd(10'd15, 32'h0, "R10 rx raw clear");

        repeat (3) @(posedge clk);
        #1;
        check(tx_exp_q.size() == 0, "R8 all strobes seen", 32'(tx_exp_q.size()), 32'h0);
        check(rd_exp_q.size() == 0, "read scoreboard drained", 32'(rd_exp_q.size()), 32'h0);
        done = 1'b1;
        summary();
    end

endmodule